// File: doc/BRIEF.md
# ECC Error Injection Unit with Key-Protected Control

This block stores 64-bit data words in a small local array and protects each word with a single-error-correcting, double-error-detecting code of 8 check bits. A write port stores words and a read port returns them one clock later. A single-bit error is corrected before the data leaves the block. A double-bit error is returned uncorrected and is marked with an error response code.

A three-register control interface lets software check the error path on purpose. A key register must first receive a fixed unlock value. After that, software can arm a fault mode that damages each newly stored word with one or two bit flips. Every error that a read detects is recorded in a sticky status register, and software clears its bits by writing ones to them. Register reads are always allowed. Register writes made while the block is locked have no effect.

Top module: `ecc_inj_unit`

## Requirements
- R1: The block has three registers: key at `reg_addr` 0, fault control at 1 and error status at 2. Writes to the fault control and error status registers take effect only while the block is unlocked. Writing 32'hF9E8D7C6 to the key register unlocks the block. The key register reads 1 when unlocked and 0 when locked.
- R2: Writing any value other than 32'hF9E8D7C6 to the key register locks the block again.
- R3: In the fault control register, bit 3 arms single-bit faults and bit 4 arms double-bit faults. All other bits read as 0. The armed setting stays in place until software writes the register again, for example with 0.
- R4: While faults are armed, every data-port write stores its data with bit 0 inverted (single) or with bits 0 and 1 inverted (double). When both bits are set, the double fault applies. The check bits are always computed from the unmodified data. Words written before arming are not affected.
- R5: A read pulse on `mem_rd` gives `rd_valid` high in the next cycle, together with `rd_data` and `rd_resp`. A clean word returns its stored data with `rd_resp` = 2'b00.
- R6: A word with one flipped bit returns the corrected data with `rd_resp` = 2'b00 and sets status bit 3.
- R7: A word with two flipped bits returns `rd_resp` = 2'b10, sets status bit 4, and returns the stored data without correction.
- R8: Writing a 1 to status bit 3 or bit 4 clears only that bit. Status writes made while locked are ignored.
- R9: After reset the block is locked, both the fault control and status registers read 0, and `rd_valid` is low.
- R10: Status bits stay set through later clean reads until software clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 key, 1 fault control, 2 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| mem_wr | input | 1 | Data word write strobe |
| mem_rd | input | 1 | Data word read strobe |
| mem_addr | input | ADDR_W | Word address |
| mem_wdata | input | 64 | Data word to store |
| rd_valid | output | 1 | Read result valid, one cycle after `mem_rd` |
| rd_data | output | 64 | Read data, corrected when a single error is found |
| rd_resp | output | 2 | Read response: 2'b00 OKAY, 2'b10 SLVERR |

## Verification
The bench sweeps every word address under each of the four fault-control settings: none, single, double, and both bits set together. The data patterns place ones and zeros at bits 0 and 1, so a missing flip, a miscorrection and a wrong precedence each give a different returned word and response. Further sequences cover:
- stores made before arming, and stores made after disarming;
- writes attempted while locked;
- a wrong key that locks the block again;
- partial write-one-to-clear of the status bits;
- status bits that survive later clean reads.

// File: rtl/ecc_inj_pkg.sv
// Package: shared constants, response type and SECDED helper functions.
// Assumes a 64-bit data word; a bit's Hamming position skips powers of two.
package ecc_inj_pkg;
    localparam int DATA_W = 64;
    localparam int HAM_W  = 7;
    localparam int CODE_W = DATA_W + HAM_W + 1;

    localparam logic [1:0]  ADDR_KEY  = 2'd0;
    localparam logic [1:0]  ADDR_CTRL = 2'd1;
    localparam logic [1:0]  ADDR_STAT = 2'd2;
    localparam logic [31:0] UNLOCK_KEY = 32'hF9E8D7C6;
    localparam int SGL_BIT = 3;
    localparam int DBL_BIT = 4;

    typedef enum logic [1:0] {
        RESP_OKAY   = 2'b00,
        RESP_SLVERR = 2'b10
    } resp_e;

    // Hamming position (1-based, never a power of two) of data bit k
    function automatic logic [HAM_W-1:0] data_pos(input int k);
        logic [HAM_W-1:0] r;
        int cnt;
        r   = '0;
        cnt = 0;
        for (int i = 3; i < 128; i++) begin
            if ((i & (i - 1)) != 0) begin
                if (cnt == k) r = HAM_W'(i);
                cnt++;
            end
        end
        return r;
    endfunction

    // Hamming check bits: XOR of the positions of all set data bits
    function automatic logic [HAM_W-1:0] ham_bits(input logic [DATA_W-1:0] d);
        logic [HAM_W-1:0] s;
        s = '0;
        for (int k = 0; k < DATA_W; k++) begin
            if (d[k]) s ^= data_pos(k);
        end
        return s;
    endfunction
endpackage

// File: rtl/ecc_inj_enc.sv
// Encoder: computes 7 Hamming bits plus an overall parity bit for one word.
// Assumes a purely combinational use; the caller supplies the unmodified data.
module ecc_inj_enc
    import ecc_inj_pkg::*;
(
    input  logic [DATA_W-1:0]  data,
    output logic [HAM_W:0]     check
);
    logic [HAM_W-1:0] ham;

    // Check bits: Hamming part and overall parity over data and Hamming part
    always_comb begin
        ham   = ham_bits(data);
        check = {(^data) ^ (^ham), ham};
    end
endmodule

// File: rtl/ecc_inj_dec.sv
// Decoder: finds the syndrome of a stored codeword, corrects one error and
// flags two. A word flagged as double is passed through without correction.
// Assumes codeword layout {overall parity, Hamming bits, data}.
module ecc_inj_dec
    import ecc_inj_pkg::*;
(
    input  logic [CODE_W-1:0] cw,
    output logic [DATA_W-1:0] data,
    output logic              sec,
    output logic              ded
);
    localparam logic [HAM_W-1:0] MAX_POS = HAM_W'(CODE_W - 1);

    logic [DATA_W-1:0] raw;
    logic [HAM_W-1:0]  syn;
    logic              par;
    logic [DATA_W-1:0] fix;

    // Syndrome, overall parity and error classification
    always_comb begin
        raw = cw[DATA_W-1:0];
        syn = ham_bits(raw) ^ cw[DATA_W +: HAM_W];
        par = ^cw;
        sec = par && (syn <= MAX_POS);
        ded = (!par && (syn != '0)) || (par && (syn > MAX_POS));
    end

    // Per-bit correction mask: flip the data bit whose position equals the syndrome
    for (genvar k = 0; k < DATA_W; k++) begin : g_fix
        localparam logic [HAM_W-1:0] POS = data_pos(k);
        assign fix[k] = sec && (syn == POS);
    end

    // Output data: corrected unless the error is uncorrectable
    always_comb begin
        data = ded ? raw : (raw ^ fix);
    end
endmodule

// File: rtl/ecc_inj_regs.sv
// Control registers: key lock, fault control and sticky error status.
// Assumes single-cycle write strobes; reads are combinational on reg_addr.
module ecc_inj_regs
    import ecc_inj_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    input  logic        sec_evt,
    input  logic        ded_evt,
    output logic [31:0] reg_rdata,
    output logic        inj_single,
    output logic        inj_double
);
    logic       unlocked_q;
    logic [1:0] ctrl_q;     // {double, single}
    logic [1:0] stat_q;     // {double seen, single seen}
    logic       wr_key, wr_ctrl, wr_stat;
    logic [1:0] clr;

    // Write decode: control and status writes need the unlocked state
    always_comb begin
        wr_key  = reg_wr && (reg_addr == ADDR_KEY);
        wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL) && unlocked_q;
        wr_stat = reg_wr && (reg_addr == ADDR_STAT) && unlocked_q;
        clr     = wr_stat ? {reg_wdata[DBL_BIT], reg_wdata[SGL_BIT]} : 2'b00;
    end

    // Lock state: the key unlocks, any other value locks
    always_ff @(posedge clk) begin
        if (!rst_n)      unlocked_q <= 1'b0;
        else if (wr_key) unlocked_q <= (reg_wdata == UNLOCK_KEY);
    end

    // Fault control: keeps only the two arming bits
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= 2'b00;
        else if (wr_ctrl) ctrl_q <= {reg_wdata[DBL_BIT], reg_wdata[SGL_BIT]};
    end

    // Status: a new error event takes priority over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= 2'b00;
        else        stat_q <= (stat_q & ~clr) | {ded_evt, sec_evt};
    end

    // Register read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_KEY:  reg_rdata[0]       = unlocked_q;
            ADDR_CTRL: begin
                reg_rdata[SGL_BIT] = ctrl_q[0];
                reg_rdata[DBL_BIT] = ctrl_q[1];
            end
            ADDR_STAT: begin
                reg_rdata[SGL_BIT] = stat_q[0];
                reg_rdata[DBL_BIT] = stat_q[1];
            end
            default:   reg_rdata = '0;
        endcase
    end

    assign inj_single = ctrl_q[0];
    assign inj_double = ctrl_q[1];

    AST_LOCKED_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked_q && reg_wr && reg_addr == ADDR_CTRL) |=> $stable(ctrl_q)); // R1

    AST_WRONG_KEY_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_KEY && reg_wdata != UNLOCK_KEY) |=> !unlocked_q); // R2

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[0] && !(reg_wr && reg_addr == ADDR_STAT && reg_wdata[SGL_BIT]))
        |=> stat_q[0]); // R10

    AST_LOCKED_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked_q && stat_q[1]) |=> stat_q[1]); // R8
endmodule

// File: rtl/ecc_inj_unit.sv
// Top: protected word store with fault insertion on write and checked reads.
// Assumes mem_wr and mem_rd are not raised in the same cycle; the array has
// no reset, so software writes a word before reading it.
module ecc_inj_unit
    import ecc_inj_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              mem_wr,
    input  logic              mem_rd,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [63:0]       mem_wdata,
    output logic              rd_valid,
    output logic [63:0]       rd_data,
    output logic [1:0]        rd_resp
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [CODE_W-1:0] store [DEPTH];
    logic [HAM_W:0]    wr_check;
    logic [DATA_W-1:0] flip;
    logic              inj_single, inj_double;
    logic [DATA_W-1:0] dec_data;
    logic              dec_sec, dec_ded;
    logic              sec_evt, ded_evt;

    ecc_inj_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .sec_evt    (sec_evt),
        .ded_evt    (ded_evt),
        .reg_rdata  (reg_rdata),
        .inj_single (inj_single),
        .inj_double (inj_double)
    );

    ecc_inj_enc u_enc (
        .data  (mem_wdata),
        .check (wr_check)
    );

    ecc_inj_dec u_dec (
        .cw   (store[mem_addr]),
        .data (dec_data),
        .sec  (dec_sec),
        .ded  (dec_ded)
    );

    // Fault mask: double takes priority over single
    always_comb begin
        flip = '0;
        if (inj_double)      flip[1:0] = 2'b11;
        else if (inj_single) flip[0]   = 1'b1;
    end

    // Word store: check bits come from clean data, the data may be damaged
    always_ff @(posedge clk) begin
        if (mem_wr) store[mem_addr] <= {wr_check, mem_wdata ^ flip};
    end

    // Error events are reported only on reads
    assign sec_evt = mem_rd && dec_sec;
    assign ded_evt = mem_rd && dec_ded;

    // Read result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_resp  <= RESP_OKAY;
        end else begin
            rd_valid <= mem_rd;
            if (mem_rd) begin
                rd_data <= dec_data;
                rd_resp <= dec_ded ? RESP_SLVERR : RESP_OKAY;
            end
        end
    end

    AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> rd_valid); // R5

    AST_RESP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_resp == RESP_OKAY || rd_resp == RESP_SLVERR)); // R5

    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> $onehot0({dec_sec, dec_ded})); // R6

    AST_SLVERR_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_resp == RESP_SLVERR) |-> reg_addr != ADDR_STAT || reg_rdata[DBL_BIT]); // R7
endmodule

// File: tb/ecc_inj_unit_tb.sv
`timescale 1ns/1ps
module ecc_inj_unit_tb;
    localparam int ADDR_W = 4;
    localparam logic [31:0] KEY = 32'hF9E8D7C6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [1:0]        reg_addr = 2'd0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              mem_wr = 1'b0;
    logic              mem_rd = 1'b0;
    logic [ADDR_W-1:0] mem_addr = '0;
    logic [63:0]       mem_wdata = '0;
    logic              rd_valid;
    logic [63:0]       rd_data;
    logic [1:0]        rd_resp;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ecc_inj_unit #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_resp(rd_resp)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic word_write(input logic [ADDR_W-1:0] a, input logic [63:0] d);
        @(negedge clk);
        mem_wr = 1'b1; mem_addr = a; mem_wdata = d;
        @(negedge clk);
        mem_wr = 1'b0;
    endtask

    task automatic word_read(input logic [ADDR_W-1:0] a, output logic v,
                             output logic [63:0] d, output logic [1:0] r);
        @(negedge clk);
        mem_rd = 1'b1; mem_addr = a;
        @(negedge clk);
        mem_rd = 1'b0;
        v = rd_valid; d = rd_data; r = rd_resp;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] rv;
        logic        v;
        logic [63:0] d;
        logic [1:0]  r;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        reg_read(2'd0, rv); check(rv == 0, "R9 key reg after reset", 64'(rv), 0);
        reg_read(2'd1, rv); check(rv == 0, "R9 ctrl after reset", 64'(rv), 0);
        reg_read(2'd2, rv); check(rv == 0, "R9 status after reset", 64'(rv), 0);
        check(rd_valid == 0, "R9 rd_valid after reset", 64'(rd_valid), 0);

        // R1 locked writes ignored at the ports
        reg_write(2'd1, 32'h10);
        reg_read(2'd1, rv); check(rv == 0, "R1 locked ctrl write ignored", 64'(rv), 0);
        word_write(4'd0, 64'h3);
        word_read(4'd0, v, d, r);
        check(d == 64'h3 && r == 2'b00, "R1 locked write stores clean", d, 64'h3);
        reg_read(2'd2, rv); check(rv == 0, "R1 no status after clean read", 64'(rv), 0);

        // R1 unlock
        reg_write(2'd0, KEY);
        reg_read(2'd0, rv); check(rv == 1, "R1 unlocked readback", 64'(rv), 1);

        // R3 unused bits read zero
        reg_write(2'd1, 32'hFFFF_FFFF);
        reg_read(2'd1, rv); check(rv == 32'h18, "R3 ctrl keeps bits 3,4 only", 64'(rv), 64'h18);
        reg_write(2'd1, 32'h0);

        // R4/R5/R6/R7 sweep: all addresses, all four control settings
        for (int mode = 0; mode < 4; mode++) begin
            reg_write(2'd1, 32'(mode) << 3);
            for (int a = 0; a < (1 << ADDR_W); a++) begin
                logic [63:0] pat, exp_d;
                logic [1:0]  exp_r;
                logic [31:0] exp_s;
                pat = (64'h1 << (a * 4 + mode)) ^ {32'hA5C3_0000 ^ 32'(a), 30'(a * 7), 2'(a + mode)};
                exp_d = pat; exp_r = 2'b00; exp_s = 0;
                if (mode >= 2) begin exp_d = pat ^ 64'h3; exp_r = 2'b10; exp_s = 32'h10; end
                else if (mode == 1) exp_s = 32'h8;
                word_write(4'(a), pat);
                word_read(4'(a), v, d, r);
                check(v == 1'b1, "R5 rd_valid one cycle after read", 64'(v), 1);
                check(d == exp_d, "R4 R6 R7 sweep data", d, exp_d);
                check(r == exp_r, "R5 R6 R7 sweep resp", 64'(r), 64'(exp_r));
                reg_read(2'd2, rv);
                check(rv == exp_s, "R6 R7 sweep status", 64'(rv), 64'(exp_s));
                reg_write(2'd2, 32'h18);
                reg_read(2'd2, rv);
                check(rv == 0, "R8 status cleared", 64'(rv), 0);
            end
        end
        reg_write(2'd1, 32'h0);

        // R4 word stored before arming stays clean
        word_write(4'd5, 64'hFFFF_0000_1234_5678);
        reg_write(2'd1, 32'h10);
        word_read(4'd5, v, d, r);
        check(d == 64'hFFFF_0000_1234_5678 && r == 2'b00, "R4 pre-arm word clean", d, 64'hFFFF_0000_1234_5678);

        // R3 stays armed until cleared, then disarm takes effect
        word_write(4'd6, 64'h10);
        reg_write(2'd1, 32'h0);
        word_write(4'd7, 64'h10);
        word_read(4'd6, v, d, r);
        check(r == 2'b10 && d == 64'h13, "R3 armed write damaged", d, 64'h13);
        word_read(4'd7, v, d, r);
        check(r == 2'b00 && d == 64'h10, "R3 disarmed write clean", d, 64'h10);

        // R10 sticky through clean read; R8 partial clear
        reg_write(2'd1, 32'h8);
        word_write(4'd8, 64'h0);
        reg_write(2'd1, 32'h0);
        word_read(4'd8, v, d, r);
        check(d == 0 && r == 2'b00, "R6 corrected zero word", d, 0);
        word_read(4'd7, v, d, r);
        reg_read(2'd2, rv); check(rv == 32'h18, "R10 both bits sticky", 64'(rv), 64'h18);
        reg_write(2'd2, 32'h8);
        reg_read(2'd2, rv); check(rv == 32'h10, "R8 clear bit 3 only", 64'(rv), 64'h10);

        // R2 wrong key relocks; R8 locked clear ignored
        reg_write(2'd0, 32'hF9E8D7C7);
        reg_read(2'd0, rv); check(rv == 0, "R2 relocked", 64'(rv), 0);
        reg_write(2'd2, 32'h10);
        reg_read(2'd2, rv); check(rv == 32'h10, "R8 locked clear ignored", 64'(rv), 64'h10);
        reg_write(2'd1, 32'h8);
        reg_read(2'd1, rv); check(rv == 0, "R2 ctrl locked again", 64'(rv), 0);

        repeat (2) @(negedge clk);
        check(rd_valid == 0, "R5 rd_valid drops", 64'(rd_valid), 0);
        finish_run();
    end
endmodule